// File: doc/BRIEF.md
# D-Channel Receive Message FIFO

This block buffers the octets of received D-channel HDLC frames between the line-side deframer and a host processor. The deframer has already removed flags, stuffed zero bits and the two check-sequence octets, and has computed the CRC (polynomial x^16 + x^12 + x^5 + 1). It hands over payload octets one per transfer. With the last octet of a frame it supplies a pass/fail bit for that CRC. The buffer holds 128 octets, organised as two 64-octet blocks that the host empties one at a time.

The host is told when to act by two interrupt lines. "Message ready" means a full 64-octet block of a frame that has not yet ended is waiting. "Message end" means the final block of a frame, holding 1 to 64 octets, is waiting together with the frame's status. While either line is high, a count output gives the number of valid octets in the presented block. The host pops the octets one by one from a read-data port and then acknowledges. The acknowledge frees the block for the writer and lets the next interrupt through.

The write side is a valid/ready stream with no back-pressure. After reset, `wr_ready` stays high, because a line receiver cannot pause. If an octet arrives while both blocks are still held by the host, it is lost, and so is the rest of its frame. The frame is then reported as aborted through an overflow status bit. The parameters `BLK_BYTES` and `NUM_BLKS` must be powers of two, and `NUM_BLKS` must be at least 2.

Top module: `dch_rx_msg_fifo`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `irq_rdy`, `irq_end`, `blk_count`, `stat_crc_ok`, `stat_ovf` and `rd_data` are all 0. `wr_ready` is 0 while reset is held.
- R2: From the first cycle after reset, `wr_ready` stays 1. Every cycle with `wr_valid` high transfers one octet, and the source is never stalled.
- R3: When the 64th octet of a block arrives and is not marked last, `irq_rdy` rises with `blk_count` = 64 and both status bits at 0. `rd_data` shows the block's octets in arrival order, and each `rd_pop` advances one octet.
- R4: An octet marked `wr_last` closes its block. `irq_end` rises with `blk_count` equal to the number of octets in that final block (1 to 64), and `stat_crc_ok` equals the `wr_crc_ok` value given with that last octet.
- R5: A final block that holds exactly 64 octets is reported with `irq_end`, not `irq_rdy`, and `blk_count` = 64.
- R6: At most one of `irq_rdy` and `irq_end` is high at any time. A presented block keeps its interrupt line and `blk_count` unchanged until `rd_ack`. In the cycle after an accepted `rd_ack`, both lines are 0. Blocks are presented in the order they were closed.
- R7: `rd_pop` and `rd_ack` have no effect while neither interrupt is high. A `rd_pop` after all `blk_count` octets have been read is ignored. When there is no valid octet to show, `rd_data` reads 0.
- R8: The buffer holds two blocks (128 octets). The writer reuses a block's space only after the host has acknowledged that block.
- R9: An octet that arrives when the writer needs a new block but the next block is still held is dropped, and so is the rest of its frame. Once a block is free, that frame is reported after all earlier blocks as `irq_end` with `stat_ovf` = 1, `stat_crc_ok` = 0 and `blk_count` = 0.
- R10: If `rd_pop` and `rd_ack` are high in the same cycle, the acknowledge takes effect and the pop is ignored. The next block starts reading at its first octet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write octet valid |
| wr_ready | output | 1 | Write ready, high from the first cycle after reset |
| wr_data | input | 8 | Payload octet |
| wr_last | input | 1 | Marks the final octet of a frame |
| wr_crc_ok | input | 1 | CRC result of the frame, taken with the last octet |
| rd_pop | input | 1 | Host pops one octet of the presented block |
| rd_ack | input | 1 | Host acknowledges and releases the presented block |
| rd_data | output | 8 | Current octet of the presented block |
| irq_rdy | output | 1 | Message-ready interrupt (full block, frame continues) |
| irq_end | output | 1 | Message-end interrupt (final block of a frame) |
| blk_count | output | 7 | Valid octets in the presented block |
| stat_crc_ok | output | 1 | Frame CRC passed (with irq_end) |
| stat_ovf | output | 1 | Frame aborted by overflow (with irq_end) |

## Verification
The hardest state to reach is an aborted frame whose report has to wait. That happens when both blocks are held and unacknowledged, and an octet then needs a third block. The bench gets there by writing frames of 129 and 130 octets, and a short frame behind a 100-octet frame, with the host kept idle. It then acknowledges block by block and checks that the abort report comes after the held blocks. A length sweep over 1 to 128 octets covers every split between ready blocks and a final block, including finals of exactly 64.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic {BLK_PART = 1'b0, BLK_LAST = 1'b1} blk_kind_e;

  typedef struct packed {
    logic crc_ok;
    logic ovf;
  } blk_stat_t;
endpackage

// File: rtl/rxf_mem.sv
module rxf_mem #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store_q[waddr] <= wdata;
  end

  assign rdata = store_q[raddr];
endmodule

// File: rtl/rxf_slot_table.sv
module rxf_slot_table
  import rxf_pkg::*;
#(
  parameter int NUM_BLKS = 2,
  parameter int CW       = 7,
  localparam int SW      = $clog2(NUM_BLKS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            close_vld,
  input  logic [SW-1:0]   close_idx,
  input  blk_kind_e       close_kind,
  input  logic [CW-1:0]   close_cnt,
  input  blk_stat_t       close_stat,
  input  logic            rel_vld,
  input  logic [SW-1:0]   rel_idx,
  input  logic [SW-1:0]   sel_idx,
  output logic [NUM_BLKS-1:0] busy,
  output logic            sel_busy,
  output blk_kind_e       sel_kind,
  output logic [CW-1:0]   sel_cnt,
  output blk_stat_t       sel_stat
);
  blk_kind_e     kind_arr [NUM_BLKS];
  logic [CW-1:0] cnt_arr  [NUM_BLKS];
  blk_stat_t     stat_arr [NUM_BLKS];

  for (genvar i = 0; i < NUM_BLKS; i++) begin : g_slot
    logic          busy_q;
    blk_kind_e     kind_q;
    logic [CW-1:0] cnt_q;
    blk_stat_t     stat_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy_q <= 1'b0;
        kind_q <= BLK_PART;
        cnt_q  <= '0;
        stat_q <= '0;
      end else if (close_vld && close_idx == SW'(i)) begin
        busy_q <= 1'b1;
        kind_q <= close_kind;
        cnt_q  <= close_cnt;
        stat_q <= close_stat;
      end else if (rel_vld && rel_idx == SW'(i)) begin
        busy_q <= 1'b0;
      end
    end

    assign busy[i]     = busy_q;
    assign kind_arr[i] = kind_q;
    assign cnt_arr[i]  = cnt_q;
    assign stat_arr[i] = stat_q;
  end

  assign sel_busy = busy[sel_idx];
  assign sel_kind = kind_arr[sel_idx];
  assign sel_cnt  = cnt_arr[sel_idx];
  assign sel_stat = stat_arr[sel_idx];
endmodule

// File: rtl/rxf_wr_ctrl.sv
module rxf_wr_ctrl
  import rxf_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BLK_BYTES = 64,
  parameter int NUM_BLKS  = 2,
  localparam int OW       = $clog2(BLK_BYTES),
  localparam int SW       = $clog2(NUM_BLKS),
  localparam int AW       = SW + OW,
  localparam int CW       = $clog2(BLK_BYTES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                wr_last,
  input  logic                wr_crc_ok,
  input  logic [NUM_BLKS-1:0] slot_busy,
  output logic                mem_we,
  output logic [AW-1:0]       mem_waddr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic                close_vld,
  output logic [SW-1:0]       close_idx,
  output blk_kind_e           close_kind,
  output logic [CW-1:0]       close_cnt,
  output blk_stat_t           close_stat
);
  logic          ready_q;
  logic [SW-1:0] ws_q;
  logic [OW-1:0] wcnt_q;
  logic          discard_q;
  logic          abort_q;
  logic          take;
  logic          cur_busy;
  logic [SW-1:0] ws_nxt;

  assign take      = wr_valid && ready_q;
  assign cur_busy  = slot_busy[ws_q];
  assign ws_nxt    = (ws_q == SW'(NUM_BLKS - 1)) ? '0 : ws_q + 1'b1;
  assign wr_ready  = ready_q;
  assign mem_waddr = {ws_q, wcnt_q};
  assign mem_wdata = wr_data;
  assign close_idx = ws_q;

  always_comb begin
    mem_we     = 1'b0;
    close_vld  = 1'b0;
    close_kind = BLK_PART;
    close_cnt  = '0;
    close_stat = '0;
    if (abort_q) begin
      if (!cur_busy) begin
        close_vld  = 1'b1;
        close_kind = BLK_LAST;
        close_stat = '{crc_ok: 1'b0, ovf: 1'b1};
      end
    end else if (take && !discard_q && !cur_busy) begin
      mem_we = 1'b1;
      if (wr_last) begin
        close_vld  = 1'b1;
        close_kind = BLK_LAST;
        close_cnt  = CW'(wcnt_q) + CW'(1);
        close_stat = '{crc_ok: wr_crc_ok, ovf: 1'b0};
      end else if (wcnt_q == OW'(BLK_BYTES - 1)) begin
        close_vld  = 1'b1;
        close_cnt  = CW'(BLK_BYTES);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q   <= 1'b0;
      ws_q      <= '0;
      wcnt_q    <= '0;
      discard_q <= 1'b0;
      abort_q   <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      if (abort_q) begin
        if (!cur_busy) begin
          ws_q    <= ws_nxt;
          abort_q <= 1'b0;
        end
        if (take) discard_q <= !wr_last;
      end else if (take) begin
        if (discard_q) begin
          if (wr_last) begin
            discard_q <= 1'b0;
            abort_q   <= 1'b1;
          end
        end else if (cur_busy) begin
          if (wr_last) abort_q   <= 1'b1;
          else         discard_q <= 1'b1;
        end else if (close_vld) begin
          ws_q   <= ws_nxt;
          wcnt_q <= '0;
        end else begin
          wcnt_q <= wcnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rxf_rd_ctrl.sv
module rxf_rd_ctrl
  import rxf_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BLK_BYTES = 64,
  parameter int NUM_BLKS  = 2,
  localparam int OW       = $clog2(BLK_BYTES),
  localparam int SW       = $clog2(NUM_BLKS),
  localparam int AW       = SW + OW,
  localparam int CW       = $clog2(BLK_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_pop,
  input  logic              rd_ack,
  input  logic              sel_busy,
  input  blk_kind_e         sel_kind,
  input  logic [CW-1:0]     sel_cnt,
  input  blk_stat_t         sel_stat,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [SW-1:0]     sel_idx,
  output logic [AW-1:0]     mem_raddr,
  output logic              rel_vld,
  output logic [SW-1:0]     rel_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_rdy,
  output logic              irq_end,
  output logic [CW-1:0]     blk_count,
  output logic              stat_crc_ok,
  output logic              stat_ovf
);
  logic [SW-1:0] rs_q;
  logic [CW-1:0] roff_q;
  logic          gap_q;
  logic          have;
  logic          byte_ok;

  assign have        = sel_busy && !gap_q;
  assign byte_ok     = have && (roff_q < sel_cnt);
  assign sel_idx     = rs_q;
  assign mem_raddr   = {rs_q, roff_q[OW-1:0]};
  assign rel_vld     = have && rd_ack;
  assign rel_idx     = rs_q;
  assign rd_data     = byte_ok ? mem_rdata : '0;
  assign irq_rdy     = have && (sel_kind == BLK_PART);
  assign irq_end     = have && (sel_kind == BLK_LAST);
  assign blk_count   = have ? sel_cnt : '0;
  assign stat_crc_ok = irq_end && sel_stat.crc_ok;
  assign stat_ovf    = irq_end && sel_stat.ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q   <= '0;
      roff_q <= '0;
      gap_q  <= 1'b0;
    end else begin
      gap_q <= rel_vld;
      if (rel_vld) begin
        rs_q   <= (rs_q == SW'(NUM_BLKS - 1)) ? '0 : rs_q + 1'b1;
        roff_q <= '0;
      end else if (rd_pop && byte_ok) begin
        roff_q <= roff_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dch_rx_msg_fifo.sv
module dch_rx_msg_fifo
  import rxf_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BLK_BYTES = 64,
  parameter int NUM_BLKS  = 2,
  localparam int OW       = $clog2(BLK_BYTES),
  localparam int SW       = $clog2(NUM_BLKS),
  localparam int AW       = SW + OW,
  localparam int DEPTH    = BLK_BYTES * NUM_BLKS,
  localparam int CW       = $clog2(BLK_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_last,
  input  logic              wr_crc_ok,
  input  logic              rd_pop,
  input  logic              rd_ack,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_rdy,
  output logic              irq_end,
  output logic [CW-1:0]     blk_count,
  output logic              stat_crc_ok,
  output logic              stat_ovf
);
  logic                mem_we;
  logic [AW-1:0]       mem_waddr;
  logic [DATA_W-1:0]   mem_wdata;
  logic [AW-1:0]       mem_raddr;
  logic [DATA_W-1:0]   mem_rdata;
  logic                close_vld;
  logic [SW-1:0]       close_idx;
  blk_kind_e           close_kind;
  logic [CW-1:0]       close_cnt;
  blk_stat_t           close_stat;
  logic                rel_vld;
  logic [SW-1:0]       rel_idx;
  logic [SW-1:0]       sel_idx;
  logic [NUM_BLKS-1:0] busy;
  logic                sel_busy;
  blk_kind_e           sel_kind;
  logic [CW-1:0]       sel_cnt;
  blk_stat_t           sel_stat;

  rxf_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  rxf_wr_ctrl #(.DATA_W(DATA_W), .BLK_BYTES(BLK_BYTES), .NUM_BLKS(NUM_BLKS)) u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_data    (wr_data),
    .wr_last    (wr_last),
    .wr_crc_ok  (wr_crc_ok),
    .slot_busy  (busy),
    .mem_we     (mem_we),
    .mem_waddr  (mem_waddr),
    .mem_wdata  (mem_wdata),
    .close_vld  (close_vld),
    .close_idx  (close_idx),
    .close_kind (close_kind),
    .close_cnt  (close_cnt),
    .close_stat (close_stat)
  );

  rxf_slot_table #(.NUM_BLKS(NUM_BLKS), .CW(CW)) u_slots (
    .clk        (clk),
    .rst_n      (rst_n),
    .close_vld  (close_vld),
    .close_idx  (close_idx),
    .close_kind (close_kind),
    .close_cnt  (close_cnt),
    .close_stat (close_stat),
    .rel_vld    (rel_vld),
    .rel_idx    (rel_idx),
    .sel_idx    (sel_idx),
    .busy       (busy),
    .sel_busy   (sel_busy),
    .sel_kind   (sel_kind),
    .sel_cnt    (sel_cnt),
    .sel_stat   (sel_stat)
  );

  rxf_rd_ctrl #(.DATA_W(DATA_W), .BLK_BYTES(BLK_BYTES), .NUM_BLKS(NUM_BLKS)) u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_pop      (rd_pop),
    .rd_ack      (rd_ack),
    .sel_busy    (sel_busy),
    .sel_kind    (sel_kind),
    .sel_cnt     (sel_cnt),
    .sel_stat    (sel_stat),
    .mem_rdata   (mem_rdata),
    .sel_idx     (sel_idx),
    .mem_raddr   (mem_raddr),
    .rel_vld     (rel_vld),
    .rel_idx     (rel_idx),
    .rd_data     (rd_data),
    .irq_rdy     (irq_rdy),
    .irq_end     (irq_end),
    .blk_count   (blk_count),
    .stat_crc_ok (stat_crc_ok),
    .stat_ovf    (stat_ovf)
  );
endmodule

// File: rtl/dch_rx_msg_fifo_chk.sv
module dch_rx_msg_fifo_chk #(
  parameter int DATA_W    = 8,
  parameter int BLK_BYTES = 64,
  localparam int CW       = $clog2(BLK_BYTES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_ack,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq_rdy,
  input logic              irq_end,
  input logic [CW-1:0]     blk_count,
  input logic              stat_crc_ok,
  input logic              stat_ovf
);
  AST_ONE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_rdy && irq_end)); // R6

  AST_RDY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rdy |-> (blk_count == CW'(BLK_BYTES)) && !stat_crc_ok && !stat_ovf); // R3

  AST_END_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_end && !stat_ovf) |-> (blk_count >= CW'(1)) && (blk_count <= CW'(BLK_BYTES))); // R4

  AST_OVF_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_end && stat_ovf) |-> (blk_count == '0) && !stat_crc_ok); // R9

  AST_HOLD_TILL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_rdy || irq_end) && !rd_ack) |=> $stable(irq_rdy) && $stable(irq_end) && $stable(blk_count)); // R6

  AST_ACK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_rdy || irq_end) && rd_ack) |=> !irq_rdy && !irq_end); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_rdy || irq_end) |-> (blk_count == '0) && !stat_crc_ok && !stat_ovf && (rd_data == '0)); // R7
endmodule

bind dch_rx_msg_fifo dch_rx_msg_fifo_chk #(.DATA_W(DATA_W), .BLK_BYTES(BLK_BYTES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_ack      (rd_ack),
  .rd_data     (rd_data),
  .irq_rdy     (irq_rdy),
  .irq_end     (irq_end),
  .blk_count   (blk_count),
  .stat_crc_ok (stat_crc_ok),
  .stat_ovf    (stat_ovf)
);

// File: tb/dch_rx_msg_fifo_tb_top.sv
module dch_rx_msg_fifo_tb_top;
  localparam int BLK = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_data = '0;
  logic       wr_last = 1'b0;
  logic       wr_crc_ok = 1'b0;
  logic       rd_pop = 1'b0;
  logic       rd_ack = 1'b0;
  logic [7:0] rd_data;
  logic       irq_rdy;
  logic       irq_end;
  logic [6:0] blk_count;
  logic       stat_crc_ok;
  logic       stat_ovf;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dch_rx_msg_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_last(wr_last), .wr_crc_ok(wr_crc_ok),
    .rd_pop(rd_pop), .rd_ack(rd_ack), .rd_data(rd_data),
    .irq_rdy(irq_rdy), .irq_end(irq_end), .blk_count(blk_count),
    .stat_crc_ok(stat_crc_ok), .stat_ovf(stat_ovf)
  );

  function automatic logic [7:0] pat(int f, int i);
    return 8'((f * 37 + i * 11 + 5) & 255);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr_frame(int fid, int len, bit crc);
    for (int i = 0; i < len; i++) begin
      wr_valid  = 1'b1;
      wr_data   = pat(fid, i);
      wr_last   = (i == len - 1);
      wr_crc_ok = crc;
      chk(wr_ready == 1'b1, "R2 ready during frame", int'(wr_ready), 1);
      @(negedge clk);
    end
    wr_valid = 1'b0;
    wr_last  = 1'b0;
  endtask

  task automatic wait_irq();
    for (int n = 0; n < 300 && !(irq_rdy || irq_end); n++) @(negedge clk);
  endtask

  // Serves the presented block: type, count, status, hold, octets, over-pop, ack gap.
  task automatic serve(bit exp_end, int exp_cnt, bit exp_crc, bit exp_ovf,
                       int fid, int base, string tag);
    wait_irq();
    chk(irq_end == exp_end && irq_rdy == !exp_end, {tag, " irq kind"},
        int'({irq_rdy, irq_end}), exp_end ? 1 : 2);
    chk(int'(blk_count) == exp_cnt, {tag, " count"}, int'(blk_count), exp_cnt);
    chk(stat_crc_ok == exp_crc && stat_ovf == exp_ovf, {tag, " status"},
        int'({stat_crc_ok, stat_ovf}), int'({exp_crc, exp_ovf}));
    repeat (2) @(negedge clk);
    chk(irq_end == exp_end && int'(blk_count) == exp_cnt, "R6 held until ack",
        int'(blk_count), exp_cnt);
    for (int j = 0; j < exp_cnt; j++) begin
      chk(rd_data == pat(fid, base + j), {tag, " data"}, int'(rd_data), int'(pat(fid, base + j)));
      rd_pop = 1'b1;
      @(negedge clk);
      rd_pop = 1'b0;
    end
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    chk(rd_data == 8'h00 && int'(blk_count) == exp_cnt, "R7 pop past end",
        int'(rd_data), 0);
    rd_ack = 1'b1;
    @(negedge clk);
    rd_ack = 1'b0;
    chk(!irq_rdy && !irq_end, "R6 gap after ack", int'({irq_rdy, irq_end}), 0);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(wr_ready == 1'b0 && !irq_rdy && !irq_end && blk_count == 0,
        "R1 in reset", int'(wr_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!irq_rdy && !irq_end && blk_count == 0 && !stat_crc_ok && !stat_ovf && rd_data == 0,
        "R1 after reset", int'({irq_rdy, irq_end, blk_count}), 0);
    chk(wr_ready == 1'b1, "R2 ready after reset", int'(wr_ready), 1);

    // R7: pop and ack with nothing presented.
    rd_pop = 1'b1;
    rd_ack = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    rd_ack = 1'b0;
    chk(!irq_rdy && !irq_end && rd_data == 0, "R7 idle pop/ack", int'(rd_data), 0);

    // Length sweep over every split of one frame into blocks (R3, R4, R5).
    for (int len = 1; len <= 2 * BLK; len++) begin
      int rem;
      int base;
      wr_frame(len, len, len[0]);
      rem  = len;
      base = 0;
      while (rem > BLK) begin
        serve(1'b0, BLK, 1'b0, 1'b0, len, base, "R3");
        rem  -= BLK;
        base += BLK;
      end
      serve(1'b1, rem, len[0], 1'b0, len, base, (rem == BLK) ? "R5" : "R4");
    end

    // R9: overflow with the frame continuing, then with the overflowing octet last.
    wr_frame(200, 130, 1'b1);
    serve(1'b0, BLK, 1'b0, 1'b0, 200, 0, "R9 held block 0");
    serve(1'b0, BLK, 1'b0, 1'b0, 200, BLK, "R9 held block 1");
    serve(1'b1, 0, 1'b0, 1'b1, 200, 0, "R9 abort report");
    wr_frame(201, 129, 1'b1);
    serve(1'b0, BLK, 1'b0, 1'b0, 201, 0, "R9 held block 0");
    serve(1'b0, BLK, 1'b0, 1'b0, 201, BLK, "R9 held block 1");
    serve(1'b1, 0, 1'b0, 1'b1, 201, 0, "R9 last-octet abort");

    // R8: two held blocks block a whole short frame; space is reused after ack.
    wr_frame(202, 100, 1'b1);
    wr_frame(203, 5, 1'b1);
    serve(1'b0, BLK, 1'b0, 1'b0, 202, 0, "R8 first block");
    serve(1'b1, 36, 1'b1, 1'b0, 202, BLK, "R8 second block");
    serve(1'b1, 0, 1'b0, 1'b1, 203, 0, "R8 no space abort");
    wr_frame(204, 5, 1'b0);
    serve(1'b1, 5, 1'b0, 1'b0, 204, 0, "R8 reuse");

    // R10: pop and ack together after a partial read.
    wr_frame(205, 100, 1'b0);
    wait_irq();
    chk(irq_rdy == 1'b1, "R10 ready", int'(irq_rdy), 1);
    for (int j = 0; j < 3; j++) begin
      chk(rd_data == pat(205, j), "R10 partial data", int'(rd_data), int'(pat(205, j)));
      rd_pop = 1'b1;
      @(negedge clk);
      rd_pop = 1'b0;
    end
    rd_pop = 1'b1;
    rd_ack = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    rd_ack = 1'b0;
    chk(!irq_rdy && !irq_end, "R10 gap", int'({irq_rdy, irq_end}), 0);
    serve(1'b1, 36, 1'b0, 1'b0, 205, BLK, "R10 next block from start");

    done = 1'b1;
    report();
  end
endmodule